// File: doc/BRIEF.md
# High-Resolution PWM Dead-Time Generator

This block turns a duty-cycle command into a pair of complementary gate drives, one for the high-side switch and one for the low-side switch of a synchronous buck stage. All switching times are counted in ticks. A tick is one sixteenth of a clock period. Each gate output changes on a clock-cycle boundary. With each gate comes a pair of 4-bit phase codes, and an external delay line uses them to move each rising or falling edge later by that many ticks inside its cycle. Timing resolution is therefore sixteen times finer than the clock: about 607 ps with a 103 MHz master clock. That resolution applies to the pulse width and to the dead time alike.

The period is given in whole clock cycles. The duty command, the dead time and the two on-time limits are given in ticks. The block latches all of these only at the clock edge that opens a period, so a command written in the middle of a period never cuts the current pulse short. The high-side on-time is clamped between a programmable floor and a programmable ceiling. Dead time is inserted at both handovers. When the enable is low, both gates are held off and the period counter returns to zero.

Top module: `hrpwm_gen`

## Requirements
- R1: A time of t ticks within a period appears as a gate transition at the start of period cycle t/16 (integer division), together with the phase code t mod 16 on that edge's phase output. The low 4 bits of a tick value are its phase and the upper bits are its cycle count.
- R2: Let P be the period in cycles, D the dead time in ticks and T the clamped on-time in ticks. In each period the high-side gate is on over ticks [D, T) and the low-side gate is on over ticks [T+D, 16·P). Period cycle 0 is the cycle that follows the opening edge.
- R3: The two gates are never on in the same cycle. When one gate falls and the other rises in the same cycle, the rising edge's phase code is not smaller than the falling edge's phase code.
- R4: A duty command below the on-time floor is raised to the floor, provided the floor does not exceed the ceiling or the period length.
- R5: A duty command above the ceiling is cut to the ceiling. The ceiling takes precedence over the floor, and the on-time never exceeds 16·P ticks.
- R6: Duty, period, dead time and both limits are sampled only at the edge that opens a period. A period opens at the first enabled edge after idle, and after cycle P−1. Between openings the counter stays below P and the phase outputs stay constant.
- R7: An edge that samples the enable low forces both gates and all four phase codes to 0 and returns the counter to 0. The next edge that samples the enable high opens a new period.
- R8: A gate pulse whose start and end fall in the same clock cycle is dropped for that period: the gate stays off and both of its phase codes read 0.
- R9: A period command of 0 is treated as a period of 1 cycle.
- R10: While reset is asserted, and until the first enabled edge after it, both gates and all phase codes are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| en_i | input | 1 | Run enable; low holds both gates off |
| duty_i | input | CW+4 | Commanded high-side on-time in ticks |
| period_i | input | CW | Period in whole clock cycles |
| dead_i | input | DW | Dead time in ticks, applied at both handovers |
| on_min_i | input | CW+4 | On-time floor in ticks |
| on_max_i | input | CW+4 | On-time ceiling in ticks |
| gh_o | output | 1 | High-side gate drive |
| gl_o | output | 1 | Low-side gate drive |
| gh_rise_ph_o | output | 4 | Fine delay code for the high-side rising edge |
| gh_fall_ph_o | output | 4 | Fine delay code for the high-side falling edge |
| gl_rise_ph_o | output | 4 | Fine delay code for the low-side rising edge |
| gl_fall_ph_o | output | 4 | Fine delay code for the low-side falling edge |

## Verification
Several properties are checked on every cycle. The gates never overlap, and a same-cycle handover keeps its edges in order. The clamped on-time respects the ceiling, the period length and, when it can, the floor. The counter stays inside the latched period. The phase codes hold between period openings, and an idle enable clears everything. Other behaviour can only be shown by the bench's scenarios, where a tick-level reference model is compared every cycle. That covers where each edge lands in cycle and phase, the choice between floor and ceiling when they conflict, the dropping of same-cycle pulses, the zero-period substitute, and the handling of commands that change in mid-period or while the enable toggles.

// File: rtl/hrpwm_pkg.sv
package hrpwm_pkg;
  // Ticks per clock cycle are 2**FINE_W
  localparam int FINE_W = 4;
  // Gate indices inside the per-gate arrays
  localparam int HI_IDX = 0;
  localparam int LO_IDX = 1;
  localparam int N_GATE = 2;
endpackage

// File: rtl/hrpwm_timebase.sv
module hrpwm_timebase #(
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  logic [CW-1:0] period_i,
  output logic [CW-1:0] per_eff_o,
  output logic [CW-1:0] cnt_nx_o,
  output logic          ld_o
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] per_q, per_d;
  logic          run_q, run_d;
  logic          ld;

  // zero period is replaced by one cycle
  assign per_eff_o = (period_i == '0) ? CW'(1) : period_i;

  always_comb begin
    ld    = en_i && (!run_q || (cnt_q == per_q - CW'(1)));
    run_d = en_i;
    per_d = ld ? per_eff_o : per_q;
    if (!en_i)   cnt_d = '0;
    else if (ld) cnt_d = '0;
    else         cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      per_q <= '0;
      run_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      run_q <= run_d;
      if (ld) per_q <= per_d;
    end
  end

  assign cnt_nx_o = cnt_d;
  assign ld_o     = ld;

  assert_cnt_in_period_R6: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (cnt_q < per_q));
  assert_period_nonzero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (per_q != '0));
endmodule

// File: rtl/hrpwm_ontime_clamp.sv
module hrpwm_ontime_clamp #(
  parameter int TW = 14,
  parameter int KW = TW + 1
) (
  input  logic [TW-1:0] duty_i,
  input  logic [TW-1:0] on_min_i,
  input  logic [TW-1:0] on_max_i,
  input  logic [KW-1:0] p16_i,
  output logic [KW-1:0] on_o
);
  logic [KW-1:0] duty_x, min_x, max_x, floored, ceiled;

  always_comb begin
    duty_x  = KW'(duty_i);
    min_x   = KW'(on_min_i);
    max_x   = KW'(on_max_i);
    // floor first, then ceiling so the ceiling wins, then period bound
    floored = (duty_x < min_x) ? min_x : duty_x;
    ceiled  = (floored > max_x) ? max_x : floored;
    on_o    = (ceiled > p16_i) ? p16_i : ceiled;
  end
endmodule

// File: rtl/hrpwm_edge_plan.sv
module hrpwm_edge_plan #(
  parameter int KW = 15,
  parameter int DW = 8,
  parameter int FW = hrpwm_pkg::FINE_W,
  parameter int XW = KW - FW
) (
  input  logic [KW-1:0] on_i,
  input  logic [DW-1:0] dead_i,
  input  logic [KW-1:0] p16_i,
  output logic [hrpwm_pkg::N_GATE-1:0][XW-1:0] rise_c_o,
  output logic [hrpwm_pkg::N_GATE-1:0][XW-1:0] fall_c_o,
  output logic [hrpwm_pkg::N_GATE-1:0][FW-1:0] rise_ph_o,
  output logic [hrpwm_pkg::N_GATE-1:0][FW-1:0] fall_ph_o,
  output logic [hrpwm_pkg::N_GATE-1:0]         valid_o
);
  import hrpwm_pkg::*;

  logic [N_GATE-1:0][KW-1:0] rise_t, fall_t;

  // high side: dead time after period start until on-time
  assign rise_t[HI_IDX] = KW'(dead_i);
  assign fall_t[HI_IDX] = on_i;
  // low side: dead time after high side ends until period end
  assign rise_t[LO_IDX] = on_i + KW'(dead_i);
  assign fall_t[LO_IDX] = p16_i;

  for (genvar g = 0; g < N_GATE; g++) begin : g_split
    assign rise_c_o[g]  = rise_t[g][KW-1:FW];
    assign fall_c_o[g]  = fall_t[g][KW-1:FW];
    assign rise_ph_o[g] = rise_t[g][FW-1:0];
    assign fall_ph_o[g] = fall_t[g][FW-1:0];
    assign valid_o[g]   = fall_t[g][KW-1:FW] > rise_t[g][KW-1:FW];
  end
endmodule

// File: rtl/hrpwm_gate.sv
module hrpwm_gate #(
  parameter int CW = 10,
  parameter int XW = CW + 1,
  parameter int FW = hrpwm_pkg::FINE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  logic          ld_i,
  input  logic [CW-1:0] cnt_nx_i,
  input  logic [XW-1:0] rise_c_i,
  input  logic [XW-1:0] fall_c_i,
  input  logic [FW-1:0] rise_ph_i,
  input  logic [FW-1:0] fall_ph_i,
  input  logic          valid_i,
  output logic          gate_o,
  output logic [FW-1:0] rise_ph_o,
  output logic [FW-1:0] fall_ph_o
);
  logic [XW-1:0] rc_q, rc_d, fc_q, fc_d;
  logic [FW-1:0] rp_q, rp_d, fp_q, fp_d;
  logic          v_q, v_d;
  logic          gate_q, gate_d;
  logic          upd;
  logic [XW-1:0] cnt_x;

  always_comb begin
    upd   = !en_i || ld_i;
    cnt_x = XW'(cnt_nx_i);
    if (!en_i) begin
      rc_d = '0; fc_d = '0; rp_d = '0; fp_d = '0; v_d = 1'b0;
    end else if (ld_i) begin
      rc_d = rise_c_i;
      fc_d = fall_c_i;
      v_d  = valid_i;
      rp_d = valid_i ? rise_ph_i : '0;
      fp_d = valid_i ? fall_ph_i : '0;
    end else begin
      rc_d = rc_q; fc_d = fc_q; rp_d = rp_q; fp_d = fp_q; v_d = v_q;
    end
    gate_d = en_i && v_d && (cnt_x >= rc_d) && (cnt_x < fc_d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rc_q   <= '0;
      fc_q   <= '0;
      rp_q   <= '0;
      fp_q   <= '0;
      v_q    <= 1'b0;
      gate_q <= 1'b0;
    end else begin
      gate_q <= gate_d;
      if (upd) begin
        rc_q <= rc_d;
        fc_q <= fc_d;
        rp_q <= rp_d;
        fp_q <= fp_d;
        v_q  <= v_d;
      end
    end
  end

  assign gate_o    = gate_q;
  assign rise_ph_o = rp_q;
  assign fall_ph_o = fp_q;

  assert_phase_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !ld_i) |=> ($stable(rise_ph_o) && $stable(fall_ph_o)));
  assert_idle_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (!gate_o && rise_ph_o == '0 && fall_ph_o == '0));
  assert_dropped_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && ld_i && !valid_i) |=> (!gate_o && rise_ph_o == '0 && fall_ph_o == '0));
endmodule

// File: rtl/hrpwm_gen.sv
module hrpwm_gen #(
  parameter int CW = 10,
  parameter int DW = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        en_i,
  input  logic [CW+hrpwm_pkg::FINE_W-1:0] duty_i,
  input  logic [CW-1:0]               period_i,
  input  logic [DW-1:0]               dead_i,
  input  logic [CW+hrpwm_pkg::FINE_W-1:0] on_min_i,
  input  logic [CW+hrpwm_pkg::FINE_W-1:0] on_max_i,
  output logic                        gh_o,
  output logic                        gl_o,
  output logic [hrpwm_pkg::FINE_W-1:0] gh_rise_ph_o,
  output logic [hrpwm_pkg::FINE_W-1:0] gh_fall_ph_o,
  output logic [hrpwm_pkg::FINE_W-1:0] gl_rise_ph_o,
  output logic [hrpwm_pkg::FINE_W-1:0] gl_fall_ph_o
);
  import hrpwm_pkg::*;

  localparam int FW = FINE_W;
  localparam int TW = CW + FW;
  localparam int KW = TW + 1;
  localparam int XW = KW - FW;

  // reset synchronizer: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  logic [CW-1:0] per_eff, cnt_nx;
  logic          ld;
  logic [KW-1:0] p16, on_w;

  hrpwm_timebase #(.CW(CW)) u_tb (
    .clk       (clk),
    .rst_n     (rst_ni),
    .en_i      (en_i),
    .period_i  (period_i),
    .per_eff_o (per_eff),
    .cnt_nx_o  (cnt_nx),
    .ld_o      (ld)
  );

  assign p16 = {1'b0, per_eff, {FW{1'b0}}};

  hrpwm_ontime_clamp #(.TW(TW), .KW(KW)) u_clamp (
    .duty_i   (duty_i),
    .on_min_i (on_min_i),
    .on_max_i (on_max_i),
    .p16_i    (p16),
    .on_o     (on_w)
  );

  logic [N_GATE-1:0][XW-1:0] rise_c, fall_c;
  logic [N_GATE-1:0][FW-1:0] rise_ph, fall_ph, rph_o, fph_o;
  logic [N_GATE-1:0]         valid, gate_w;

  hrpwm_edge_plan #(.KW(KW), .DW(DW), .FW(FW), .XW(XW)) u_plan (
    .on_i      (on_w),
    .dead_i    (dead_i),
    .p16_i     (p16),
    .rise_c_o  (rise_c),
    .fall_c_o  (fall_c),
    .rise_ph_o (rise_ph),
    .fall_ph_o (fall_ph),
    .valid_o   (valid)
  );

  for (genvar g = 0; g < N_GATE; g++) begin : g_gate
    hrpwm_gate #(.CW(CW), .XW(XW), .FW(FW)) u_gate (
      .clk       (clk),
      .rst_n     (rst_ni),
      .en_i      (en_i),
      .ld_i      (ld),
      .cnt_nx_i  (cnt_nx),
      .rise_c_i  (rise_c[g]),
      .fall_c_i  (fall_c[g]),
      .rise_ph_i (rise_ph[g]),
      .fall_ph_i (fall_ph[g]),
      .valid_i   (valid[g]),
      .gate_o    (gate_w[g]),
      .rise_ph_o (rph_o[g]),
      .fall_ph_o (fph_o[g])
    );
  end

  assign gh_o         = gate_w[HI_IDX];
  assign gl_o         = gate_w[LO_IDX];
  assign gh_rise_ph_o = rph_o[HI_IDX];
  assign gh_fall_ph_o = fph_o[HI_IDX];
  assign gl_rise_ph_o = rph_o[LO_IDX];
  assign gl_fall_ph_o = fph_o[LO_IDX];

  assert_no_overlap_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    !(gh_o && gl_o));
  assert_handover_lo_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    ($fell(gh_o) && $rose(gl_o)) |-> (gl_rise_ph_o >= gh_fall_ph_o));
  assert_handover_hi_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    ($fell(gl_o) && $rose(gh_o)) |-> (gh_rise_ph_o >= gl_fall_ph_o));
  assert_on_ceiling_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    (on_w <= KW'(on_max_i)) && (on_w <= p16));
  assert_on_floor_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    ((on_min_i <= on_max_i) && (KW'(on_min_i) <= p16)) |-> (on_w >= KW'(on_min_i)));
endmodule

// File: tb/hrpwm_gen_test.sv
`timescale 1ns/1ps
module hrpwm_gen_test;
  localparam int CW = 10;
  localparam int DW = 8;
  localparam int TW = CW + 4;
  localparam int MAXV = (1 << TW) - 1;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n;
  logic          en;
  logic [TW-1:0] duty, on_min, on_max;
  logic [CW-1:0] period;
  logic [DW-1:0] dead;
  logic          gh, gl;
  logic [3:0]    ghr, ghf, glr, glf;

  hrpwm_gen #(.CW(CW), .DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .en_i(en), .duty_i(duty), .period_i(period),
    .dead_i(dead), .on_min_i(on_min), .on_max_i(on_max),
    .gh_o(gh), .gl_o(gl), .gh_rise_ph_o(ghr), .gh_fall_ph_o(ghf),
    .gl_rise_ph_o(glr), .gl_fall_ph_o(glf)
  );

  int    tests = 0;
  int    fails = 0;
  string tag = "R10";

  // reference model state, all in ticks and cycles
  int m_run = 0, m_cnt = 0, m_per = 0;
  int h_on = 0, h_off = 0, l_on = 0, l_off = 0;
  bit h_ok = 0, l_ok = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n || !en) begin
      m_run = 0; m_cnt = 0; h_ok = 0; l_ok = 0;
    end else if (m_run == 0 || m_cnt == m_per - 1) begin
      int t;
      int full;
      m_per = (period == 0) ? 1 : int'(period);
      full  = m_per * 16;
      t = int'(duty);
      if (t < int'(on_min)) t = int'(on_min);
      if (t > int'(on_max)) t = int'(on_max);
      if (t > full) t = full;
      h_on  = int'(dead);  h_off = t;
      l_on  = t + int'(dead); l_off = full;
      h_ok  = (h_off / 16) > (h_on / 16);
      l_ok  = (l_off / 16) > (l_on / 16);
      m_cnt = 0; m_run = 1;
    end else begin
      m_cnt = m_cnt + 1;
    end
  end

  always @(negedge clk) begin
    logic [17:0] act, exp_v;
    bit e_gh, e_gl;
    e_gh = h_ok && m_cnt >= h_on / 16 && m_cnt < h_off / 16;
    e_gl = l_ok && m_cnt >= l_on / 16 && m_cnt < l_off / 16;
    act   = {gh, gl, ghr, ghf, glr, glf};
    exp_v = {e_gh, e_gl,
             h_ok ? 4'(h_on % 16) : 4'd0, h_ok ? 4'(h_off % 16) : 4'd0,
             l_ok ? 4'(l_on % 16) : 4'd0, l_ok ? 4'(l_off % 16) : 4'd0};
    tests++;
    if (act !== exp_v) begin
      fails++;
      $display("FAIL %s: outputs act=%h exp=%h at t=%0t", tag, act, exp_v, $time);
    end
    tests++;
    if (gh === 1'b1 && gl === 1'b1) begin
      fails++;
      $display("FAIL R3: overlap act=%b%b exp=no overlap at t=%0t", gh, gl, $time);
    end
  end

  task automatic drive(input int d, input int p, input int dt, input int mn, input int mx);
    duty = TW'(d); period = CW'(p); dead = DW'(dt); on_min = TW'(mn); on_max = TW'(mx);
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; en = 1'b0;
    drive(50, 8, 5, 0, MAXV);
    wait_cyc(4);
    rst_n = 1'b1;
    wait_cyc(4);
    // R1: edge at tick 5 and 50, low side 55..128
    tag = "R1"; en = 1'b1; wait_cyc(30);
    // R2: larger dead time crossing a cycle, and zero dead time
    tag = "R2"; drive(70, 10, 20, 0, MAXV); wait_cyc(40);
    drive(64, 8, 0, 0, MAXV); wait_cyc(24);
    // R6: commands changing inside a period
    tag = "R6"; drive(40, 8, 5, 0, MAXV); wait_cyc(3);
    drive(100, 12, 9, 0, MAXV); wait_cyc(3);
    drive(20, 6, 2, 0, MAXV); wait_cyc(30);
    // R4: floor raises a short command
    tag = "R4"; drive(10, 8, 4, 40, MAXV); wait_cyc(20);
    // R5: ceiling, ceiling over floor, period bound
    tag = "R5"; drive(200, 8, 4, 0, 100); wait_cyc(20);
    drive(10, 8, 4, 90, 60); wait_cyc(20);
    drive(300, 8, 4, 0, MAXV); wait_cyc(20);
    // R8: pulses inside one cycle are dropped
    tag = "R8"; drive(10, 8, 3, 0, MAXV); wait_cyc(20);
    drive(120, 8, 6, 0, MAXV); wait_cyc(20);
    // R9: zero period
    tag = "R9"; drive(5, 0, 1, 0, MAXV); wait_cyc(10);
    drive(20, 0, 2, 0, MAXV); wait_cyc(10);
    // R7: enable toggles mid-period
    tag = "R7"; drive(50, 8, 5, 0, MAXV); wait_cyc(5);
    en = 1'b0; wait_cyc(4);
    en = 1'b1; wait_cyc(3);
    en = 1'b0; wait_cyc(1);
    en = 1'b1; wait_cyc(20);
    // R3: varied commands, checked for overlap and placement
    tag = "R3";
    for (int i = 0; i < 60; i++) begin
      drive($urandom_range(0, 400), $urandom_range(0, 20), $urandom_range(0, 255),
            $urandom_range(0, 200), $urandom_range(0, 400));
      wait_cyc($urandom_range(1, 25));
    end
    tag = "R7"; en = 1'b0; wait_cyc(4);
    tag = "R10"; rst_n = 1'b0; wait_cyc(3);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: act=running exp=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule